// File: doc/BRIEF.md
# Masked Block-Write Datapath

This unit is the write side of a synchronous graphics memory. It turns each sampled command into one registered write beat for a column array. The beat carries a column-group address, eight per-column write enables, a 32-bit per-bit write enable and a write data word. The array stores the enabled bits of the data word into every enabled column of the addressed group. The unit keeps two long-lived registers, a bit-write mask and a fill color. Software can load them only through a register-set command that is qualified by the function-select input.

Plain writes target one column. They can be thinned per byte by the byte-mask pins and, when write-per-bit is requested, per bit by the stored mask. The stored mask stays in force until it is loaded again. A block write, also selected by the function-select input, writes the fill color into the aligned group of eight columns that contains the given column. Data-bus bits 7..0 choose which of those columns take part, and the same bit and byte gating applies.

All inputs are sampled on the rising clock edge. Outputs appear one edge later.

Top module: `gfx_write_unit`

## Requirements
- R1: After synchronous reset, all column enables and bit enables are 0 and the output data word is 0. The mask register resets to all ones and the color register resets to 0.
- R2: A write with fsel=0 (cmd=1) produces, one edge later, exactly one column enable at bit col_addr[2:0]. wr_group equals col_addr shifted right by 3, and wr_data equals the sampled wdata.
- R3: During any write, byte k of wr_bit_en (bits 8k+7..8k) is 0 when byte_mask[k]=1. A mask bit of 1 blocks its byte.
- R4: During any write, bit b of wr_bit_en equals (mask bit b OR wpb=0) AND NOT byte_mask[b/8]. With wpb=0 and byte_mask=0, all 32 bits are enabled.
- R5: The mask register keeps its last loaded value across any number of writes until the next mask load.
- R6: A register-set command (cmd=2) with fsel=1 loads wdata into the mask register when col_addr[0]=0, or into the color register when col_addr[0]=1. It raises no column or bit enable.
- R7: A register-set command with fsel=0 changes neither register and raises no enable.
- R8: A write with fsel=1 is a block write. One edge later wr_col_en equals wdata[7:0], wr_group equals col_addr shifted right by 3 (the low 3 address bits are ignored), and wr_data equals the color register.
- R9: A block write applies the same bit enables as R4, so the array receives the color only in enabled bits of enabled columns.
- R10: With cmd=0 or cmd=3, one edge later all column enables and bit enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | 0 idle, 1 write, 2 register set, 3 idle |
| fsel | input | 1 | Function select: graphics variant of the command |
| wpb | input | 1 | Apply stored bit mask to this write |
| col_addr | input | COL_W | Column address; bit 0 picks the target register on register set |
| wdata | input | DATA_W | Write data, register load value, or block-write column mask in bits 7..0 |
| byte_mask | input | DATA_W/8 | Per-byte write block, 1 = byte not written |
| wr_group | output | COL_W-3 | Addressed group of eight columns |
| wr_col_en | output | 8 | Per-column write enable within the group |
| wr_bit_en | output | DATA_W | Per-bit write enable |
| wr_data | output | DATA_W | Data for every enabled column |

## Verification
On every cycle, the assertions check that idle and register-set commands leave the column and bit enables at zero. They also check that a plain write enables a single column, that a block write forwards its data-bus column mask and the color register, that fully masked bytes and unmasked writes give the expected bit-enable extremes, and that neither register moves without a qualified load. The sweeps are needed to show the rest. They show that the exact bit pattern of a stored mask persists through many writes. They show how every column mask combines with byte masks and bit masks in the cells of a modelled array. They also show that an unqualified register-set leaves the old mask in use by later writes.

// File: rtl/gfx_wr_pkg.sv
package gfx_wr_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_SETREG = 2'd2,
    CMD_SPARE  = 2'd3
  } gfx_cmd_e;

  localparam int BLK_COLS = 8;
  localparam int BLK_LOG  = 3;
  localparam int BYTE_W   = 8;
endpackage

// File: rtl/gfx_reg_file.sv
module gfx_reg_file #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mask,
  input  logic              ld_color,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] color_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      color_q <= '0;
    end else begin
      if (ld_mask)  mask_q  <= din;
      if (ld_color) color_q <= din;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_mask |=> $stable(mask_q)); // R5
  AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_color |=> $stable(color_q)); // R6
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(ld_mask && ld_color)); // R6
endmodule

// File: rtl/gfx_bit_enable.sv
module gfx_bit_enable
  import gfx_wr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] mask,
  input  logic              wpb,
  input  logic [NBYTES-1:0] byte_mask,
  output logic [DATA_W-1:0] bit_en
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign bit_en[k*BYTE_W +: BYTE_W] =
      (mask[k*BYTE_W +: BYTE_W] | {BYTE_W{~wpb}}) & {BYTE_W{~byte_mask[k]}};
  end
endmodule

// File: rtl/gfx_col_select.sv
module gfx_col_select
  import gfx_wr_pkg::*;
(
  input  logic               is_block,
  input  logic [BLK_LOG-1:0] low_idx,
  input  logic [BLK_COLS-1:0] col_bits,
  output logic [BLK_COLS-1:0] col_en
);
  for (genvar i = 0; i < BLK_COLS; i++) begin : g_col
    assign col_en[i] = is_block ? col_bits[i] : (low_idx == BLK_LOG'(i));
  end
endmodule

// File: rtl/gfx_write_unit.sv
module gfx_write_unit
  import gfx_wr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COL_W  = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int GRP_W  = COL_W - BLK_LOG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cmd,
  input  logic                fsel,
  input  logic                wpb,
  input  logic [COL_W-1:0]    col_addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NBYTES-1:0]   byte_mask,
  output logic [GRP_W-1:0]    wr_group,
  output logic [BLK_COLS-1:0] wr_col_en,
  output logic [DATA_W-1:0]   wr_bit_en,
  output logic [DATA_W-1:0]   wr_data
);
  gfx_cmd_e cmd_c;
  logic is_wr, is_blk, is_set, ld_mask, ld_color;
  logic [DATA_W-1:0]   mask_q, color_q, bit_en_c;
  logic [BLK_COLS-1:0] col_en_c;
  logic past_ok;

  assign cmd_c    = gfx_cmd_e'(cmd);
  assign is_wr    = (cmd_c == CMD_WRITE);
  assign is_blk   = is_wr & fsel;
  assign is_set   = (cmd_c == CMD_SETREG) & fsel;
  assign ld_mask  = is_set & ~col_addr[0];
  assign ld_color = is_set & col_addr[0];

  gfx_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ld_mask(ld_mask), .ld_color(ld_color),
    .din(wdata), .mask_q(mask_q), .color_q(color_q)
  );

  gfx_bit_enable #(.DATA_W(DATA_W)) u_bits (
    .mask(mask_q), .wpb(wpb), .byte_mask(byte_mask), .bit_en(bit_en_c)
  );

  gfx_col_select u_cols (
    .is_block(is_blk), .low_idx(col_addr[BLK_LOG-1:0]),
    .col_bits(wdata[BLK_COLS-1:0]), .col_en(col_en_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok   <= 1'b0;
      wr_group  <= '0;
      wr_col_en <= '0;
      wr_bit_en <= '0;
      wr_data   <= '0;
    end else begin
      past_ok <= 1'b1;
      if (is_wr) begin
        wr_group  <= col_addr[COL_W-1:BLK_LOG];
        wr_col_en <= col_en_c;
        wr_bit_en <= bit_en_c;
        wr_data   <= is_blk ? color_q : wdata;
      end else begin
        wr_col_en <= '0;
        wr_bit_en <= '0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(is_wr) |-> (wr_col_en == '0) && (wr_bit_en == '0)); // R10
  AST_SINGLE_COL: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(is_wr && !fsel) |-> $countones(wr_col_en) == 1); // R2
  AST_BLOCK_COLOR: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(is_blk) |-> wr_data == $past(color_q)); // R8
  AST_BLOCK_COLS: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(is_blk) |-> wr_col_en == $past(wdata[BLK_COLS-1:0])); // R8
  AST_BYTES_OFF: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(is_wr && (&byte_mask)) |-> wr_bit_en == '0); // R3
  AST_NO_WPB_FULL: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(is_wr && !wpb && (byte_mask == '0)) |-> (&wr_bit_en)); // R4
  AST_PLAIN_SET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cmd_c == CMD_SETREG && !fsel) |->
      (mask_q == $past(mask_q)) && (color_q == $past(color_q))); // R7
endmodule

// File: tb/test_gfx_write_unit.sv
module test_gfx_write_unit;
  localparam int DW = 32;
  localparam int CW = 5;
  localparam int NCOL = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cmd = 2'd0;
  logic          fsel = 1'b0;
  logic          wpb = 1'b0;
  logic [CW-1:0] col_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [3:0]    byte_mask = '0;
  logic [CW-4:0] wr_group;
  logic [7:0]    wr_col_en;
  logic [DW-1:0] wr_bit_en, wr_data;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] ref_mask, ref_color;
  logic [DW-1:0] ref_mem [NCOL];
  logic [DW-1:0] dut_mem [NCOL];

  gfx_write_unit #(.DATA_W(DW), .COL_W(CW)) i_gfx_write_unit (
    .clk(clk), .rst(rst), .cmd(cmd), .fsel(fsel), .wpb(wpb),
    .col_addr(col_addr), .wdata(wdata), .byte_mask(byte_mask),
    .wr_group(wr_group), .wr_col_en(wr_col_en),
    .wr_bit_en(wr_bit_en), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [DW-1:0] exp_bits(input logic [DW-1:0] m, input logic w,
                                             input logic [3:0] bm);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = (m[b] | ~w) & ~bm[b/8];
    return r;
  endfunction

  task automatic op(input logic [1:0] c, input logic f, input logic w,
                    input logic [CW-1:0] a, input logic [DW-1:0] d,
                    input logic [3:0] bm, input string req);
    logic [7:0] e_col;
    logic [DW-1:0] e_bits, e_data;
    logic wr;
    wr = (c == 2'd1);
    e_col  = wr ? (f ? d[7:0] : (8'd1 << a[2:0])) : 8'd0;
    e_bits = wr ? exp_bits(ref_mask, w, bm) : '0;
    e_data = f ? ref_color : d;
    cmd = c; fsel = f; wpb = w; col_addr = a; wdata = d; byte_mask = bm;
    @(negedge clk);
    checks++;
    if (wr_col_en !== e_col || wr_bit_en !== e_bits ||
        (wr && (wr_data !== e_data || wr_group !== a[CW-1:3]))) begin
      fails++;
      $display("FAIL %s: actual col=%h bits=%h data=%h grp=%0d expected col=%h bits=%h data=%h grp=%0d",
               req, wr_col_en, wr_bit_en, wr_data, wr_group, e_col, e_bits, e_data, a[CW-1:3]);
    end
    if (c == 2'd2 && f) begin
      if (a[0]) ref_color = d; else ref_mask = d;
    end
    for (int i = 0; i < 8; i++) begin
      if (e_col[i])
        ref_mem[{a[CW-1:3], 3'(i)}] = (ref_mem[{a[CW-1:3], 3'(i)}] & ~e_bits) | (e_data & e_bits);
      if (wr_col_en[i])
        dut_mem[{wr_group, 3'(i)}] = (dut_mem[{wr_group, 3'(i)}] & ~wr_bit_en) | (wr_data & wr_bit_en);
    end
    cmd = 2'd0;
  endtask

  initial begin
    ref_mask = '1;
    ref_color = '0;
    for (int i = 0; i < NCOL; i++) begin ref_mem[i] = '0; dut_mem[i] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (wr_col_en !== 8'd0 || wr_bit_en !== '0 || wr_data !== '0) begin
      fails++;
      $display("FAIL R1: actual col=%h bits=%h data=%h expected all zero", wr_col_en, wr_bit_en, wr_data);
    end
    rst = 1'b0;
    // R1: reset color is 0 and reset mask is all ones
    op(2'd1, 1'b1, 1'b1, 5'd3, 32'h0000_00FF, 4'h0, "R1");
    // R2: plain write to every column
    for (int a = 0; a < NCOL; a++)
      op(2'd1, 1'b0, 1'b0, CW'(a), 32'h1357_0000 + 32'(a * 32'h0101_0011), 4'h0, "R2");
    // R6: load mask, then idle R10
    op(2'd2, 1'b1, 1'b0, 5'd0, 32'hA5C3_0FF0, 4'h0, "R6");
    op(2'd0, 1'b0, 1'b0, 5'd7, 32'hFFFF_FFFF, 4'h0, "R10");
    op(2'd3, 1'b1, 1'b1, 5'd7, 32'hFFFF_FFFF, 4'h0, "R10");
    // R3 R4: byte-mask x wpb sweep; R5 mask persists across all of them
    for (int bm = 0; bm < 16; bm++)
      for (int w = 0; w < 2; w++)
        op(2'd1, 1'b0, w[0], CW'(bm * 2 + w), ~(32'(bm) * 32'h1111_1111), 4'(bm), "R3/R4/R5");
    // R6: reload mask, then R5 persistence
    op(2'd2, 1'b1, 1'b0, 5'd2, 32'h0F0F_33CC, 4'h0, "R6");
    for (int k = 0; k < 8; k++)
      op(2'd1, 1'b0, 1'b1, CW'(k * 3), 32'hFFFF_FFFF, 4'(k), "R5");
    // R7: unqualified register set ignored; old mask still applies
    op(2'd2, 1'b0, 1'b0, 5'd0, 32'h0000_0000, 4'h0, "R7");
    op(2'd2, 1'b0, 1'b0, 5'd1, 32'hDEAD_BEEF, 4'h0, "R7");
    op(2'd1, 1'b0, 1'b1, 5'd9, 32'hFFFF_FFFF, 4'h0, "R7");
    op(2'd1, 1'b1, 1'b0, 5'd16, 32'h0000_00FF, 4'h0, "R7");
    // R6: load color
    op(2'd2, 1'b1, 1'b0, 5'd1, 32'h6B2E_91D4, 4'h0, "R6");
    // R8 R9: every column mask, varied low address bits, bytes and wpb
    for (int m = 0; m < 256; m++)
      op(2'd1, 1'b1, m[0], CW'(m * 7), 32'hFFFF_FF00 | 32'(m), 4'(m >> 2), "R8/R9");
    op(2'd2, 1'b1, 1'b0, 5'd0, 32'hFFFF_0000, 4'h0, "R6");
    op(2'd2, 1'b1, 1'b0, 5'd1, 32'h1234_5678, 4'h0, "R6");
    for (int g = 0; g < NCOL / 8; g++)
      op(2'd1, 1'b1, 1'b1, CW'(g * 8 + 5), 32'h0000_00A5, 4'(g), "R9");
    for (int i = 0; i < NCOL; i++) begin
      checks++;
      if (dut_mem[i] !== ref_mem[i]) begin
        fails++;
        $display("FAIL R9 array col %0d: actual=%h expected=%h", i, dut_mem[i], ref_mem[i]);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule